// File: doc/BRIEF.md
# Byte-wide I/O register bank

This block sits behind a host I/O port and answers cycles in an eight-byte window. A two-bit strap picks the window base from four choices spaced 1000h apart, starting at 0300h. The first six bytes of the window return a 48-bit station address supplied from outside. The seventh byte is a control/status byte. Its low half holds writable control bits: the memory-window bank select and two mode bits. Its high half shows live status inputs. The eighth byte is a read-only revision port.

The registers are all one byte wide, but the host may also issue word (16-bit) cycles. A word cycle at offset n is served as two consecutive byte registers: register n on the low data lane and register n+1 on the high lane. Read data is combinational from the address and strobes. Writes take effect on the rising clock edge.

Top module: `io_reg_bank`

## Requirements
- R1: `io_hit` is 1 exactly when `io_addr` lies in base..base+7, where base = 0300h + 1000h * `base_sel`.
- R2: A byte read at offset k (0 to 5) returns `station_addr[47-8k -: 8]` on `io_rdata[7:0]`, so offset 0 returns bits 47:40.
- R3: A byte read at offset 6 returns {`status_in[3:0]`, mode[1:0], bank[1:0]}, with bank in bits 1:0 and mode in bits 3:2.
- R4: During and after reset, `bank_sel` is 2'b11 and `mode_ctrl` is 2'b00.
- R5: A byte write at offset 6 loads `io_wdata[1:0]` into `bank_sel` and `io_wdata[3:2]` into `mode_ctrl` on the next clock edge.
- R6: Writes outside the window, writes to offsets 0 to 5 or 7, and cycles without `io_wr` leave `bank_sel` and `mode_ctrl` unchanged.
- R7: A byte read at offset 7 returns 0 in bits 7:4 and the `VERSION` parameter (default 4'h3) in bits 3:0.
- R8: A word read at offset n (0 to 6) returns register n on `io_rdata[7:0]` and register n+1 on `io_rdata[15:8]`.
- R9: A word read at offset 7 returns FFh on the high lane. A word write at offset 5 loads control from `io_wdata[11:8]`. A word write at offset 6 loads control from `io_wdata[3:0]`.
- R10: `io_rdata` is 0 when `io_rd` is low or the address misses, and `io_rdata[15:8]` is 0 on a byte read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wide | input | 1 | 1 for a word cycle, 0 for a byte cycle |
| io_wdata | input | 16 | Write data, two byte lanes |
| base_sel | input | 2 | Window base strap |
| station_addr | input | 48 | Station address value |
| status_in | input | 4 | Live status bits |
| io_rdata | output | 16 | Read data, two byte lanes |
| io_hit | output | 1 | Address falls in the window |
| bank_sel | output | 2 | Memory window bank select |
| mode_ctrl | output | 2 | Remaining control bits |

## Verification
Every strap setting is swept over a span that begins four bytes below the window and ends four bytes past it, with byte and word reads at each address. This separates a base-decode fault from a register-select fault and shows whether the high lane is offset by one. Two station address patterns with distinct bytes are used, so a swapped or reversed byte order cannot read back correctly. Write sequences cover each lane route into the control byte and each case that must leave it untouched.

// File: rtl/io_reg_pkg.sv
package io_reg_pkg;
   localparam int BYTE_W   = 8;
   localparam int NUM_REGS = 8;
   localparam int OFF_W    = $clog2(NUM_REGS);
   localparam int SA_BYTES = 6;
   localparam int LANES    = 2;

   localparam logic [OFF_W-1:0] OFF_CTRL = 3'd6;
   localparam logic [OFF_W-1:0] OFF_VER  = 3'd7;

   typedef logic [BYTE_W-1:0] byte_t;

   function automatic logic [15:0] window_base(input logic [1:0] sel);
      return 16'h0300 + {2'b00, sel, 12'h000};
   endfunction
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
   import io_reg_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        base_sel,
   output logic              hit,
   output logic [OFF_W-1:0]  offset
);
   localparam int TAG_W = ADDR_W - OFF_W;

   logic [15:0]      base;
   logic [TAG_W-1:0] base_tag;

   assign base = window_base(base_sel);

   generate
      if (ADDR_W > 16) begin : g_wide_addr
         assign base_tag = {{(ADDR_W-16){1'b0}}, base[15:OFF_W]};
      end else begin : g_std_addr
         assign base_tag = base[15:OFF_W];
      end
   endgenerate

   assign hit    = (addr[ADDR_W-1:OFF_W] == base_tag);
   assign offset = addr[OFF_W-1:0];
endmodule

// File: rtl/io_ctrl_reg.sv
module io_ctrl_reg
   import io_reg_pkg::*;
#(
   parameter int CTRL_BITS = 4,
   parameter logic [CTRL_BITS-1:0] CTRL_RESET = 4'b0011
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    wide,
   input  logic [OFF_W-1:0]        offset,
   input  logic [LANES*BYTE_W-1:0] wdata,
   output logic [CTRL_BITS-1:0]    ctrl_q
);
   logic [LANES-1:0]  lane_sel;
   byte_t             lane_data [LANES];
   logic [CTRL_BITS-1:0] next_val;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         logic [OFF_W:0] target;
         assign target       = {1'b0, offset} + (OFF_W+1)'(g);
         assign lane_data[g] = wdata[g*BYTE_W +: BYTE_W];
         if (g == 0) begin : g_low
            assign lane_sel[g] = (target == {1'b0, OFF_CTRL});
         end else begin : g_high
            assign lane_sel[g] = wide && (target == {1'b0, OFF_CTRL});
         end
      end
   endgenerate

   always_comb begin
      next_val = ctrl_q;
      for (int i = 0; i < LANES; i++) begin
         if (lane_sel[i]) next_val = lane_data[i][CTRL_BITS-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= CTRL_RESET;
      else if (wr_en) ctrl_q <= next_val;
   end

   logic unused_bits;
   assign unused_bits = ^{lane_data[0][BYTE_W-1:CTRL_BITS],
                          lane_data[1][BYTE_W-1:CTRL_BITS]};
endmodule

// File: rtl/io_read_mux.sv
module io_read_mux
   import io_reg_pkg::*;
#(
   parameter int CTRL_BITS = 4,
   parameter int STATUS_W  = 4,
   parameter logic [3:0] VERSION = 4'h3
) (
   input  logic                       rd_en,
   input  logic                       wide,
   input  logic [OFF_W-1:0]           offset,
   input  logic [SA_BYTES*BYTE_W-1:0] station_addr,
   input  logic [CTRL_BITS-1:0]       ctrl_q,
   input  logic [STATUS_W-1:0]        status_in,
   output logic [LANES*BYTE_W-1:0]    rdata
);
   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         logic [OFF_W:0] idx;
         byte_t          val;
         logic           lane_on;
         assign idx = {1'b0, offset} + (OFF_W+1)'(g);
         if (g == 0) begin : g_low
            assign lane_on = rd_en;
         end else begin : g_high
            assign lane_on = rd_en && wide;
         end

         always_comb begin
            val = 8'hFF;
            for (int k = 0; k < SA_BYTES; k++) begin
               if (idx == (OFF_W+1)'(k))
                  val = station_addr[(SA_BYTES-1-k)*BYTE_W +: BYTE_W];
            end
            if (idx == {1'b0, OFF_CTRL}) val = {status_in, ctrl_q};
            if (idx == {1'b0, OFF_VER})  val = {4'h0, VERSION};
         end

         assign rdata[g*BYTE_W +: BYTE_W] = lane_on ? val : '0;
      end
   endgenerate
endmodule

// File: rtl/io_reg_bank.sv
module io_reg_bank
   import io_reg_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CTRL_BITS = 4,
   parameter int STATUS_W  = 4,
   parameter logic [3:0] VERSION = 4'h3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic                  io_rd,
   input  logic                  io_wr,
   input  logic                  io_wide,
   input  logic [15:0]           io_wdata,
   input  logic [1:0]            base_sel,
   input  logic [47:0]           station_addr,
   input  logic [STATUS_W-1:0]   status_in,
   output logic [15:0]           io_rdata,
   output logic                  io_hit,
   output logic [1:0]            bank_sel,
   output logic [CTRL_BITS-3:0]  mode_ctrl
);
   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("io_reg_bank: ADDR_W must be at least 16");
      end
      if (CTRL_BITS + STATUS_W != BYTE_W) begin : g_bad_split
         $error("io_reg_bank: control and status widths must fill one byte");
      end
      if (CTRL_BITS < 3) begin : g_bad_ctrl
         $error("io_reg_bank: CTRL_BITS must leave room for mode bits");
      end
   endgenerate

   localparam logic [CTRL_BITS-1:0] CTRL_RESET = {{(CTRL_BITS-2){1'b0}}, 2'b11};

   logic [OFF_W-1:0]     offset;
   logic [CTRL_BITS-1:0] ctrl_q;

   io_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
      .addr     (io_addr),
      .base_sel (base_sel),
      .hit      (io_hit),
      .offset   (offset)
   );

   io_ctrl_reg #(.CTRL_BITS(CTRL_BITS), .CTRL_RESET(CTRL_RESET)) ctrl_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (io_wr && io_hit),
      .wide   (io_wide),
      .offset (offset),
      .wdata  (io_wdata),
      .ctrl_q (ctrl_q)
   );

   io_read_mux #(.CTRL_BITS(CTRL_BITS), .STATUS_W(STATUS_W), .VERSION(VERSION)) rmux_i (
      .rd_en        (io_rd && io_hit),
      .wide         (io_wide),
      .offset       (offset),
      .station_addr (station_addr),
      .ctrl_q       (ctrl_q),
      .status_in    (status_in),
      .rdata        (io_rdata)
   );

   assign bank_sel  = ctrl_q[1:0];
   assign mode_ctrl = ctrl_q[CTRL_BITS-1:2];
endmodule

// File: rtl/io_reg_bank_chk.sv
module io_reg_bank_chk #(
   parameter logic [3:0] VERSION = 4'h3
) (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] io_addr,
   input logic        io_rd,
   input logic        io_wr,
   input logic        io_wide,
   input logic [15:0] io_wdata,
   input logic [1:0]  base_sel,
   input logic [15:0] io_rdata,
   input logic        io_hit,
   input logic [1:0]  bank_sel
);
   // R1
   hit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_hit |-> (io_addr[15:3] == {2'b00, base_sel, 9'h060}));

   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_hit) |-> (io_rdata == 16'h0000));

   // R7
   version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_hit && !io_wide && io_addr[2:0] == 3'd7)
         |-> (io_rdata == {12'h000, VERSION}));

   // R9
   wide_top_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_hit && io_wide && io_addr[2:0] == 3'd7)
         |-> (io_rdata[15:8] == 8'hFF));

   // R5
   bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_hit && !io_wide && io_addr[2:0] == 3'd6)
         |=> (bank_sel == $past(io_wdata[1:0])));

   // R6
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_hit) |=> $stable(bank_sel));
endmodule

bind io_reg_bank io_reg_bank_chk #(.VERSION(VERSION)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_addr  (io_addr),
   .io_rd    (io_rd),
   .io_wr    (io_wr),
   .io_wide  (io_wide),
   .io_wdata (io_wdata),
   .base_sel (base_sel),
   .io_rdata (io_rdata),
   .io_hit   (io_hit),
   .bank_sel (bank_sel)
);

// File: tb/io_reg_bank_tb_top.sv
module io_reg_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic        io_wide = 1'b0;
   logic [15:0] io_wdata = '0;
   logic [1:0]  base_sel = '0;
   logic [47:0] station_addr = '0;
   logic [3:0]  status_in = '0;
   logic [15:0] io_rdata;
   logic        io_hit;
   logic [1:0]  bank_sel;
   logic [1:0]  mode_ctrl;

   int checks = 0;
   int errors = 0;
   logic [3:0] ctrl_m = 4'b0011;

   always #2 clk = ~clk;

   io_reg_bank dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wide(io_wide), .io_wdata(io_wdata), .base_sel(base_sel),
      .station_addr(station_addr), .status_in(status_in), .io_rdata(io_rdata),
      .io_hit(io_hit), .bank_sel(bank_sel), .mode_ctrl(mode_ctrl)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (addr %h wide %0d)", req, act, exp, io_addr, io_wide);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int k);
      if (k < 6)  return station_addr[47-8*k -: 8];
      if (k == 6) return {status_in, ctrl_m};
      if (k == 7) return 8'h03;
      return 8'hFF;
   endfunction

   task automatic rd_chk(input logic [15:0] a, input logic w);
      int base, off;
      logic inwin;
      logic [15:0] exp;
      string tag;
      @(negedge clk);
      io_addr = a; io_wide = w; io_rd = 1'b1;
      #1;
      base  = 16'h0300 + 16'h1000 * int'(base_sel);
      off   = int'(a) - base;
      inwin = (off >= 0) && (off < 8);
      check("R1", {15'd0, io_hit}, {15'd0, inwin});
      if (!inwin) begin
         exp = 16'h0000; tag = "R10";
      end else begin
         exp[7:0]  = exp_byte(off);
         exp[15:8] = w ? exp_byte(off + 1) : 8'h00;
         if (w && off == 7)  tag = "R9";
         else if (w)         tag = "R8";
         else if (off < 6)   tag = "R2";
         else if (off == 6)  tag = "R3";
         else                tag = "R7";
      end
      check(tag, io_rdata, exp);
      io_rd = 1'b0;
   endtask

   task automatic wr_chk(input logic [15:0] a, input logic w, input logic [15:0] d,
                         input logic strobe, input string tag);
      int base, off;
      @(negedge clk);
      io_addr = a; io_wide = w; io_wdata = d; io_wr = strobe;
      base = 16'h0300 + 16'h1000 * int'(base_sel);
      off  = int'(a) - base;
      if (strobe && off >= 0 && off < 8) begin
         if (off == 6) ctrl_m = d[3:0];
         else if (w && off == 5) ctrl_m = d[11:8];
      end
      @(negedge clk);
      io_wr = 1'b0;
      #1;
      check(tag, {12'd0, mode_ctrl, bank_sel}, {12'd0, ctrl_m});
   endtask

   initial begin
      #(4 * 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R4: reset values
      #5;
      check("R4", {12'd0, mode_ctrl, bank_sel}, 16'h0003);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R4", {12'd0, mode_ctrl, bank_sel}, 16'h0003);

      for (int p = 0; p < 2; p++) begin
         station_addr = (p == 0) ? 48'h0123_4567_89AB : 48'hA55A_F00F_C33C;
         status_in    = (p == 0) ? 4'h9 : 4'h6;
         for (int s = 0; s < 4; s++) begin
            base_sel = 2'(s);
            for (int k = -4; k < 12; k++) begin
               rd_chk(16'(16'h0300 + 16'h1000 * s + k), 1'b0);
               rd_chk(16'(16'h0300 + 16'h1000 * s + k), 1'b1);
            end
         end
      end

      // R10: strobe low inside the window
      base_sel = 2'd1;
      @(negedge clk);
      io_addr = 16'h1300; io_rd = 1'b0; io_wide = 1'b1;
      #1;
      check("R10", io_rdata, 16'h0000);

      // R5: byte write at offset 6
      wr_chk(16'h1306, 1'b0, 16'h00F6, 1'b1, "R5");
      rd_chk(16'h1306, 1'b0);
      wr_chk(16'h1306, 1'b0, 16'h5509, 1'b1, "R5");
      // R6: ignored cases
      wr_chk(16'h0306, 1'b0, 16'h000C, 1'b1, "R6");
      wr_chk(16'h1305, 1'b0, 16'h000C, 1'b1, "R6");
      wr_chk(16'h1307, 1'b0, 16'h000C, 1'b1, "R6");
      wr_chk(16'h1300, 1'b1, 16'h0C0C, 1'b1, "R6");
      wr_chk(16'h1306, 1'b0, 16'h000C, 1'b0, "R6");
      wr_chk(16'h130E, 1'b0, 16'h000C, 1'b1, "R6");
      // R9: word write routing
      wr_chk(16'h1305, 1'b1, 16'h0A00, 1'b1, "R9");
      wr_chk(16'h1306, 1'b1, 16'h0705, 1'b1, "R9");
      wr_chk(16'h1307, 1'b1, 16'h0F0F, 1'b1, "R9");
      rd_chk(16'h1305, 1'b1);
      rd_chk(16'h1306, 1'b1);

      // R4: reset restores bank 3
      @(negedge clk);
      rst_n = 1'b0; ctrl_m = 4'b0011;
      #1;
      check("R4", {12'd0, mode_ctrl, bank_sel}, 16'h0003);
      @(negedge clk);
      rst_n = 1'b1;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule